// File: doc/BRIEF.md
# Homing and Position Preset Unit

This block sits beside the position counter of a servo axis. It keeps a signed position value that moves one step per encoder count pulse, in the direction given by a direction bit. It also produces the homing status that a host controller reads. The origin limit switch is passed back out as a detection flag. A second counter measures how many encoder pulses arrive between the switch being released and the next index (Z) marker. A short count here warns that the marker seen may be one turn late.

The preset request is a rising-edge event. It is honoured only while the drive reports zero speed. A valid preset loads the position with an unsigned 15-bit station number, marks homing as complete, and clears the latched absolute-data-lost alarm. When the preset function is not allocated to a terminal, the enable input is low and the request is treated as permanently off. The switch, index and preset inputs are asynchronous. Each passes through two synchronizing flops before any edge is taken from it.

Top module: `home_preset_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pos_q` is 0, `lsz_count` is 0, and `ls_det`, `home_done` and `abs_lost` are 0.
- R2: `ls_det` equals `ls_in` delayed by exactly two clock edges. This is the two-flop synchronizer with no further logic.
- R3: A rising edge of the synchronized switch clears `lsz_count` and stops measurement. A falling edge starts measurement. While measuring, each cycle with `cnt_pulse` high adds one to the count. The first synchronized rising edge of `z_in` stops measurement, and the value is then held.
- R4: `lsz_count` saturates at 2^LSZ_W-1 and never wraps to zero through counting.
- R5: When no preset is taken, each cycle with `cnt_pulse` high changes `pos_q` by +1 if `cnt_dir` is 1 and by -1 if `cnt_dir` is 0. The value wraps in 32-bit two's complement.
- R6: Only an off-to-on transition of the synchronized `preset_in` triggers a preset. A valid preset loads `pos_q` with `station` zero-extended to 32 bits. A level held high does not trigger again.
- R7: A preset edge that occurs while `zero_speed` is 0 is discarded and leaves `pos_q`, `home_done` and `abs_lost` unchanged.
- R8: While `preset_en` is 0, `preset_in` is treated as 0 and cannot trigger a preset.
- R9: A valid preset sets `home_done`, which stays 1 until reset.
- R10: `abs_fault` high sets `abs_lost` on the next edge. It stays set until a valid preset clears it. If a fault and a valid preset occur in the same cycle, the fault wins.
- R11: When a valid preset and `cnt_pulse` occur in the same cycle, the preset value is loaded and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pulse | input | 1 | One encoder count per cycle when high |
| cnt_dir | input | 1 | Count direction, 1 = up |
| ls_in | input | 1 | Origin limit switch, asynchronous |
| z_in | input | 1 | Encoder index marker, asynchronous |
| zero_speed | input | 1 | Speed-zero status |
| preset_in | input | 1 | Preset request, asynchronous |
| preset_en | input | 1 | Preset function allocated |
| station | input | 15 | Station number loaded by a preset |
| abs_fault | input | 1 | Absolute data loss event |
| pos_q | output | 32 | Signed current position |
| ls_det | output | 1 | Origin switch detection |
| lsz_count | output | LSZ_W | Pulses from switch release to index |
| home_done | output | 1 | Origin return complete |
| abs_lost | output | 1 | Latched absolute-data-lost alarm |

## Verification
The bench raises the preset while speed is nonzero and holds it high until speed becomes zero. A design that triggers on level would load the position there, while a correct one waits for a fresh edge. It keeps count pulses running through preset edges, which shows whether the preset or the pulse wins. It also drops the enable while the request toggles. A measurement with a known number of pulses before the index checks both the start and the stop of the switch-to-index count. A long pulse run exposes a counter that wraps instead of saturating. A fault raised in the same cycle as a preset checks which one the alarm obeys.

// File: rtl/home_pkg.sv
package home_pkg;
    localparam int POS_W = 32;
    localparam int STN_W = 15;

    typedef struct packed {
        logic ls;
        logic z;
        logic preset;
    } home_in_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t edge_of(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction
endpackage

// File: rtl/home_sync.sv
module home_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/home_lsz_meas.sv
module home_lsz_meas #(
    parameter int LSZ_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    input  logic             ls_rise,
    input  logic             ls_fall,
    input  logic             z_rise,
    output logic [LSZ_W-1:0] count
);
    localparam logic [LSZ_W-1:0] CMAX = '1;

    logic active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            count  <= '0;
        end else if (ls_rise) begin
            active <= 1'b0;
            count  <= '0;
        end else begin
            if (active && pulse && count != CMAX)
                count <= count + 1'b1;
            if (ls_fall)
                active <= 1'b1;
            else if (z_rise)
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/home_pos_reg.sv
module home_pos_reg
    import home_pkg::*;
#(
    parameter int PW = POS_W,
    parameter int SW = STN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SW-1:0]        value,
    input  logic                 pulse,
    input  logic                 dir,
    output logic signed [PW-1:0] pos
);
    localparam int PAD = PW - SW;

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (load)
            pos <= signed'({{PAD{1'b0}}, value});
        else if (pulse)
            pos <= dir ? pos + 1 : pos - 1;
    end
endmodule

// File: rtl/home_preset_unit.sv
module home_preset_unit
    import home_pkg::*;
#(
    parameter int LSZ_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cnt_pulse,
    input  logic                    cnt_dir,
    input  logic                    ls_in,
    input  logic                    z_in,
    input  logic                    zero_speed,
    input  logic                    preset_in,
    input  logic                    preset_en,
    input  logic [STN_W-1:0]        station,
    input  logic                    abs_fault,
    output logic signed [POS_W-1:0] pos_q,
    output logic                    ls_det,
    output logic [LSZ_W-1:0]        lsz_count,
    output logic                    home_done,
    output logic                    abs_lost
);
    home_in_t raw, syn, prev;
    edge_t    ls_e, z_e, pr_e;
    logic     pr_eff;
    logic     preset_ok;

    assign raw.ls     = ls_in;
    assign raw.z      = z_in;
    assign raw.preset = preset_in;

    home_sync #(.W($bits(home_in_t))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    assign pr_eff = syn.preset & preset_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
        end else begin
            prev.ls     <= syn.ls;
            prev.z      <= syn.z;
            prev.preset <= pr_eff;
        end
    end

    assign ls_e      = edge_of(syn.ls, prev.ls);
    assign z_e       = edge_of(syn.z, prev.z);
    assign pr_e      = edge_of(pr_eff, prev.preset);
    assign preset_ok = pr_e.rise & zero_speed;
    assign ls_det    = syn.ls;

    home_lsz_meas #(.LSZ_W(LSZ_W)) u_lsz (
        .clk     (clk),
        .rst     (rst),
        .pulse   (cnt_pulse),
        .ls_rise (ls_e.rise),
        .ls_fall (ls_e.fall),
        .z_rise  (z_e.rise),
        .count   (lsz_count)
    );

    home_pos_reg u_pos (
        .clk   (clk),
        .rst   (rst),
        .load  (preset_ok),
        .value (station),
        .pulse (cnt_pulse),
        .dir   (cnt_dir),
        .pos   (pos_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            home_done <= 1'b0;
            abs_lost  <= 1'b0;
        end else begin
            if (preset_ok)
                home_done <= 1'b1;
            if (abs_fault)
                abs_lost <= 1'b1;
            else if (preset_ok)
                abs_lost <= 1'b0;
        end
    end
endmodule

// File: rtl/home_preset_unit_chk.sv
module home_preset_unit_chk
    import home_pkg::*;
#(
    parameter int LSZ_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cnt_pulse,
    input logic                    cnt_dir,
    input logic                    ls_in,
    input logic                    zero_speed,
    input logic                    abs_fault,
    input logic signed [POS_W-1:0] pos_q,
    input logic                    ls_det,
    input logic [LSZ_W-1:0]        lsz_count,
    input logic                    home_done,
    input logic                    abs_lost
);
    localparam logic [LSZ_W-1:0] CMAX = '1;

    logic [1:0] since_rst;
    logic       ls_d1, ls_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 1'b1;
        end
        ls_d1 <= ls_in;
        ls_d2 <= ls_d1;
    end

    // R2
    ls_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (ls_det == ls_d2));

    // R3
    lsz_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(ls_det) |=> (lsz_count >= $past(lsz_count)));

    // R4
    lsz_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (lsz_count == CMAX) |=> (lsz_count == CMAX || lsz_count == '0));

    // R5
    pos_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_speed && cnt_pulse && cnt_dir) |=> (pos_q == $past(pos_q) + 1));

    // R5
    pos_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_speed && cnt_pulse && !cnt_dir) |=> (pos_q == $past(pos_q) - 1));

    // R7
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!zero_speed && !cnt_pulse) |=> $stable(pos_q));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        home_done |=> home_done);

    // R10
    abs_set_chk: assert property (@(posedge clk) disable iff (rst)
        abs_fault |=> abs_lost);
endmodule

bind home_preset_unit home_preset_unit_chk #(.LSZ_W(LSZ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_pulse  (cnt_pulse),
    .cnt_dir    (cnt_dir),
    .ls_in      (ls_in),
    .zero_speed (zero_speed),
    .abs_fault  (abs_fault),
    .pos_q      (pos_q),
    .ls_det     (ls_det),
    .lsz_count  (lsz_count),
    .home_done  (home_done),
    .abs_lost   (abs_lost)
);

// File: tb/home_preset_unit_tb.sv
module home_preset_unit_tb;
    localparam int LSZ_W = 12;
    localparam int CMAX  = (1 << LSZ_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cnt_pulse = 0, cnt_dir = 0, ls_in = 0, z_in = 0;
    logic               zero_speed = 0, preset_in = 0, preset_en = 1, abs_fault = 0;
    logic [14:0]        station = '0;
    logic signed [31:0] pos_q;
    logic               ls_det, home_done, abs_lost;
    logic [LSZ_W-1:0]   lsz_count;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic signed [31:0] m_pos;
    int                 m_cnt;
    bit                 m_act, m_done, m_abs;
    bit                 ls1, ls2, lsp, z1, z2, zp, p1, p2, pp;

    always #2.5 clk = ~clk;

    home_preset_unit #(.LSZ_W(LSZ_W)) u_dut (
        .clk(clk), .rst(rst), .cnt_pulse(cnt_pulse), .cnt_dir(cnt_dir),
        .ls_in(ls_in), .z_in(z_in), .zero_speed(zero_speed),
        .preset_in(preset_in), .preset_en(preset_en), .station(station),
        .abs_fault(abs_fault), .pos_q(pos_q), .ls_det(ls_det),
        .lsz_count(lsz_count), .home_done(home_done), .abs_lost(abs_lost)
    );

    always @(posedge clk) begin
        bit ls_r, ls_f, z_r, pe, ok;
        if (rst) begin
            m_pos = 0; m_cnt = 0; m_act = 0; m_done = 0; m_abs = 0;
            {ls1, ls2, lsp, z1, z2, zp, p1, p2, pp} = '0;
        end else begin
            ls_r = ls2 && !lsp;
            ls_f = !ls2 && lsp;
            z_r  = z2 && !zp;
            pe   = p2 && preset_en;
            ok   = pe && !pp && zero_speed;
            if (ls_r) begin
                m_cnt = 0; m_act = 0;
            end else begin
                if (m_act && cnt_pulse && m_cnt < CMAX) m_cnt++;
                if (ls_f) m_act = 1;
                else if (z_r) m_act = 0;
            end
            if (ok) m_pos = 32'(station);
            else if (cnt_pulse) m_pos = cnt_dir ? m_pos + 1 : m_pos - 1;
            if (ok) m_done = 1;
            if (abs_fault) m_abs = 1;
            else if (ok) m_abs = 0;
            lsp = ls2; ls2 = ls1; ls1 = ls_in;
            zp = z2; z2 = z1; z1 = z_in;
            pp = pe; p2 = p1; p1 = preset_in;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R5/R6/R11 position", pos_q, m_pos);
            check("R2 ls_det", ls_det, ls2);
            check("R3/R4 lsz_count", lsz_count, m_cnt);
            check("R9 home_done", home_done, m_done);
            check("R10 abs_lost", abs_lost, m_abs);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n, input bit dir);
        cnt_dir = dir;
        for (int i = 0; i < n; i++) begin
            cnt_pulse = 1; step(1);
        end
        cnt_pulse = 0;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        check("R1 pos", pos_q, 0);
        check("R1 count", lsz_count, 0);
        check("R1 flags", {ls_det, home_done, abs_lost}, 0);
        rst = 0;
        step(1);
        check("R1 first cycle pos", pos_q, 0);

        // R5 counting both ways, through zero
        pulses(5, 1);
        pulses(8, 0);
        step(1);
        check("R5 net -3", pos_q, -3);

        // R7 edge with speed nonzero ignored, R6 held level no retrigger
        station = 15'd1234;
        zero_speed = 0; preset_in = 1; step(6);
        zero_speed = 1; step(6);
        check("R7 ignored preset", pos_q, -3);
        check("R6 level not retriggered", home_done, 0);
        preset_in = 0; step(4);
        preset_in = 1; step(5);
        check("R6 preset loads station", pos_q, 1234);
        check("R9 done set", home_done, 1);
        preset_in = 0; step(4);

        // R10 alarm latched, cleared by preset; fault wins on collision
        abs_fault = 1; step(1); abs_fault = 0; step(3);
        check("R10 alarm latched", abs_lost, 1);
        station = 15'h7fff;
        preset_in = 1; step(5);
        check("R10 cleared by preset", abs_lost, 0);
        check("R6 full station", pos_q, 32767);
        preset_in = 0; step(4);
        preset_in = 1; step(2); abs_fault = 1; step(1); abs_fault = 0; step(3);
        check("R10 fault wins", abs_lost, 1);
        preset_in = 0; step(4);

        // R8 not allocated
        preset_en = 0; station = 15'd77;
        for (int i = 0; i < 3; i++) begin
            preset_in = 1; step(4); preset_in = 0; step(4);
        end
        check("R8 disabled preset", pos_q, 32767);
        preset_en = 1; step(4);

        // R11 preset while pulses keep arriving
        station = 15'd500; cnt_dir = 1; cnt_pulse = 1;
        preset_in = 1; step(5);
        cnt_pulse = 0; step(1);
        check("R11 preset beats pulse", pos_q, 502);
        preset_in = 0; step(4);

        // R3 measurement window
        ls_in = 1; step(6);
        check("R2 ls_det on", ls_det, 1);
        ls_in = 0; step(6);
        pulses(10, 1);
        step(2);
        z_in = 1; step(6); z_in = 0;
        pulses(7, 1);
        step(2);
        check("R3 pulses to index", lsz_count, 10);

        // R3 clear on new switch assertion, R4 saturation
        ls_in = 1; step(5);
        check("R3 cleared", lsz_count, 0);
        ls_in = 0; step(5);
        pulses(CMAX + 40, 1);
        step(2);
        check("R4 saturated", lsz_count, CMAX);

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            cnt_pulse  = ($urandom % 2) == 0;
            cnt_dir    = ($urandom % 2) == 0;
            if ($urandom % 16 == 0) ls_in = ~ls_in;
            if ($urandom % 10 == 0) z_in = ~z_in;
            if ($urandom % 8 == 0) preset_in = ~preset_in;
            zero_speed = ($urandom % 3) != 0;
            abs_fault  = ($urandom % 40) == 0;
            station    = 15'($urandom);
            step(1);
        end
        cnt_pulse = 0; abs_fault = 0;
        step(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule